// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Controller

This block watches the transmit and receive FIFOs of a serial controller and turns their levels, flags and access strobes into a status word, a set of interrupt flags, one interrupt line and two DMA request lines. It has five interrupt sources. Two of them follow the FIFO fill levels against programmable thresholds and change as soon as the levels change. The other three record error events: a push into a full transmit FIFO, a write into a full receive FIFO, and a pop from an empty receive FIFO. These three stay set until software clears them.

Software supplies a mask word, the two thresholds, a DMA enable word, and a clear strobe with a write-one clear word. Register decoding and the FIFOs themselves are outside the block. The status word, the level-driven flags, the masked flags, the interrupt line and the DMA requests are combinational functions of the inputs and of the sticky event bits. A sticky bit sets on the clock edge after its event.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: `status` reports busy on bit 0, transmit full on bit 1, transmit empty on bit 2, receive empty on bit 3 and receive full on bit 4, all combinational from the inputs.
- R2: Raw bit 0 (transmit level low) is 1 exactly while `tx_level <= tx_thresh`. It is not sticky.
- R3: Raw bit 4 (receive level high) is 1 exactly while `rx_level > rx_thresh`. It is not sticky.
- R4: Raw bit 1 (transmit overflow) sets on the edge after a cycle in which `tx_push` and `tx_full` are both high. It then holds until it is cleared.
- R5: Raw bit 3 (receive overflow) sets on the edge after a cycle in which `rx_push` and `rx_full` are both high. It then holds until it is cleared.
- R6: Raw bit 2 (receive underflow) sets on the edge after a cycle in which `rx_pop` and `rx_empty` are both high. It then holds until it is cleared.
- R7: When `clr_stb` is high, clear word bit 1 clears raw bit 2, bit 2 clears raw bit 3, and bit 3 clears raw bit 1, on the next edge.
- R8: When `clr_stb` is high, clear word bit 0 clears all three sticky bits on the next edge.
- R9: If an event and a clear for the same sticky bit occur in the same cycle, the bit is set after the edge.
- R10: `masked_irq` equals `raw_irq & irq_mask`, where a mask bit of 1 enables that source. `irq` is the OR of `masked_irq`.
- R11: `dma_rx_req` is `dma_en[0]` AND the R3 condition. `dma_tx_req` is `dma_en[1]` AND the R2 condition.
- R12: A synchronous active-low reset clears all sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | TX_LVL_W | Transmit FIFO fill level |
| rx_level | input | RX_LVL_W | Receive FIFO fill level |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_push | input | 1 | Write into transmit FIFO |
| rx_push | input | 1 | Internal write into receive FIFO |
| rx_pop | input | 1 | Read from receive FIFO |
| engine_busy | input | 1 | Serial engine busy |
| irq_mask | input | 5 | Source enables, 1 = enabled |
| tx_thresh | input | TX_LVL_W | Transmit level threshold |
| rx_thresh | input | RX_LVL_W | Receive level threshold |
| dma_en | input | 2 | Bit 0 receive, bit 1 transmit DMA enable |
| clr_stb | input | 1 | Clear word valid |
| clr_word | input | 4 | Write-one clear word |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Unmasked interrupt flags |
| masked_irq | output | 5 | Masked interrupt flags |
| irq | output | 1 | Combined interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume the FIFO inputs describe a real FIFO: each full flag is high only when its level equals the depth, and each empty flag is high only when its level is zero. The random stimulus first picks each level, biased toward the two extremes, and then derives both flags from that level, so the inputs always stay consistent. Strobes, thresholds, mask, DMA enables and clear words are drawn freely, including clears that fall in the same cycle as an event.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the FIFO status and interrupt controller.
// Assumes five interrupt sources in a fixed bit order, read by software.
package spi_irq_pkg;
    localparam int NUM_SRC = 5;
    // interrupt source bit positions
    localparam int SRC_TXL = 0;   // transmit level at/below threshold
    localparam int SRC_TXO = 1;   // transmit overflow
    localparam int SRC_RXU = 2;   // receive underflow
    localparam int SRC_RXO = 3;   // receive overflow
    localparam int SRC_RXH = 4;   // receive level above threshold
    // clear word bit positions
    localparam int CLR_W   = 4;
    localparam int CLR_ALL = 0;
    localparam int CLR_RXU = 1;
    localparam int CLR_RXO = 2;
    localparam int CLR_TXO = 3;
    // status word bit positions
    localparam int ST_W     = 5;
    localparam int ST_BUSY  = 0;
    localparam int ST_TXFUL = 1;
    localparam int ST_TXEMP = 2;
    localparam int ST_RXEMP = 3;
    localparam int ST_RXFUL = 4;
    // DMA enable bit positions
    localparam int DMA_W  = 2;
    localparam int DMA_RX = 0;
    localparam int DMA_TX = 1;

    typedef enum logic {
        CMP_AT_OR_BELOW = 1'b0,
        CMP_ABOVE       = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/spi_level_cmp.sv
// Threshold comparator for one FIFO level.
// MODE selects whether the flag is raised at/below or strictly above the threshold.
// Assumes level and threshold share the same unsigned width.
module spi_level_cmp #(
    parameter int                     LVL_W = 6,
    parameter spi_irq_pkg::cmp_mode_e MODE  = spi_irq_pkg::CMP_AT_OR_BELOW
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             hit
);
    generate
        if (MODE == spi_irq_pkg::CMP_ABOVE) begin : g_above
            // raise while the level exceeds the threshold
            always_comb hit = (level > thresh);
        end else begin : g_below
            // raise while the level does not exceed the threshold
            always_comb hit = (level <= thresh);
        end
    endgenerate
endmodule

// File: rtl/spi_sticky_evt.sv
// One sticky event flag: it sets on an event and clears on request.
// A set in the same cycle as a clear wins. Synchronous active-low reset.
module spi_sticky_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    // hold the event until it is cleared; a new event beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);
endmodule

// File: rtl/spi_irq_combine.sv
// Combines the raw flags with the mask into the masked flags and the interrupt
// line, and gates the level conditions with the DMA enables.
// Assumes the bit order from spi_irq_pkg.
module spi_irq_combine
    import spi_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [DMA_W-1:0]   dma_en,
    output logic [NUM_SRC-1:0] masked,
    output logic               irq,
    output logic               dma_tx_req,
    output logic               dma_rx_req
);
    // apply the per-source enables and merge them into one line
    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end

    // DMA requests follow the level conditions while they are enabled
    always_comb begin
        dma_tx_req = dma_en[DMA_TX] & raw[SRC_TXL];
        dma_rx_req = dma_en[DMA_RX] & raw[SRC_RXH];
    end
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
// FIFO status and interrupt controller for a serial port.
// Produces the status word, the raw and masked interrupt flags, one interrupt
// line and the DMA requests from FIFO levels, flags and strobes.
// Assumes the full and empty flags agree with the levels. Synchronous active-low reset.
module spi_fifo_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    parameter int RX_DEPTH = 32,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TX_LVL_W-1:0] tx_level,
    input  logic [RX_LVL_W-1:0] rx_level,
    input  logic                tx_full,
    input  logic                tx_empty,
    input  logic                rx_full,
    input  logic                rx_empty,
    input  logic                tx_push,
    input  logic                rx_push,
    input  logic                rx_pop,
    input  logic                engine_busy,
    input  logic [4:0]          irq_mask,
    input  logic [TX_LVL_W-1:0] tx_thresh,
    input  logic [RX_LVL_W-1:0] rx_thresh,
    input  logic [1:0]          dma_en,
    input  logic                clr_stb,
    input  logic [3:0]          clr_word,
    output logic [4:0]          status,
    output logic [4:0]          raw_irq,
    output logic [4:0]          masked_irq,
    output logic                irq,
    output logic                dma_tx_req,
    output logic                dma_rx_req
);
    // returns the clear request for one sticky source
    function automatic logic clr_for(input int src, input logic stb,
                                     input logic [CLR_W-1:0] w);
        logic one;
        case (src)
            SRC_TXO: one = w[CLR_TXO];
            SRC_RXU: one = w[CLR_RXU];
            SRC_RXO: one = w[CLR_RXO];
            default: one = 1'b0;
        endcase
        return stb & (w[CLR_ALL] | one);
    endfunction

    // returns the event that sets one sticky source
    function automatic logic evt_for(input int src, input logic txp, input logic txf,
                                     input logic rxp, input logic rxf,
                                     input logic pop, input logic rxe);
        case (src)
            SRC_TXO: return txp & txf;
            SRC_RXU: return pop & rxe;
            SRC_RXO: return rxp & rxf;
            default: return 1'b0;
        endcase
    endfunction

    logic [NUM_SRC-1:0] raw;

    // assemble the status word from the FIFO flags and engine state
    always_comb begin
        status           = '0;
        status[ST_BUSY]  = engine_busy;
        status[ST_TXFUL] = tx_full;
        status[ST_TXEMP] = tx_empty;
        status[ST_RXEMP] = rx_empty;
        status[ST_RXFUL] = rx_full;
    end

    spi_level_cmp #(.LVL_W(TX_LVL_W), .MODE(CMP_AT_OR_BELOW)) u_tx_cmp (
        .level (tx_level),
        .thresh(tx_thresh),
        .hit   (raw[SRC_TXL])
    );

    spi_level_cmp #(.LVL_W(RX_LVL_W), .MODE(CMP_ABOVE)) u_rx_cmp (
        .level (rx_level),
        .thresh(rx_thresh),
        .hit   (raw[SRC_RXH])
    );

    // one sticky flag per event source
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            if (i != SRC_TXL && i != SRC_RXH) begin : g_sticky
                spi_sticky_evt u_evt (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .set_evt(evt_for(i, tx_push, tx_full, rx_push, rx_full, rx_pop, rx_empty)),
                    .clr    (clr_for(i, clr_stb, clr_word)),
                    .flag   (raw[i])
                );
            end
        end
    endgenerate

    spi_irq_combine u_comb (
        .raw       (raw),
        .mask      (irq_mask),
        .dma_en    (dma_en),
        .masked    (masked_irq),
        .irq       (irq),
        .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req)
    );

    assign raw_irq = raw;

    p_reset_clears_r12: assert property (@(posedge clk)
        !rst_n |=> (raw_irq[SRC_TXO] == 1'b0 && raw_irq[SRC_RXU] == 1'b0
                    && raw_irq[SRC_RXO] == 1'b0));
    p_txovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> raw_irq[SRC_TXO]);
    p_rxunf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> raw_irq[SRC_RXU]);
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && clr_word[CLR_ALL] && !(rx_push && rx_full)) |=> !raw_irq[SRC_RXO]);
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_irq & irq_mask) != '0);
    p_dma_tx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> (dma_en[DMA_TX] && tx_level <= tx_thresh));
    p_dma_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (dma_en[DMA_RX] && rx_level > rx_thresh));
endmodule

// File: tb/spi_fifo_irq_ctrl_bench.sv
module spi_fifo_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] tx_level = '0, rx_level = '0, tx_thresh = '0, rx_thresh = '0;
    logic tx_full = 0, tx_empty = 1, rx_full = 0, rx_empty = 1;
    logic tx_push = 0, rx_push = 0, rx_pop = 0, engine_busy = 0, clr_stb = 0;
    logic [4:0] irq_mask = '0;
    logic [1:0] dma_en = '0;
    logic [3:0] clr_word = '0;
    logic [4:0] status, raw_irq, masked_irq;
    logic irq, dma_tx_req, dma_rx_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [4:0] m_sticky = '0;   // expected sticky bits (1,2,3)

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_irq_ctrl #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u_spi_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .engine_busy(engine_busy),
        .irq_mask(irq_mask), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .dma_en(dma_en),
        .clr_stb(clr_stb), .clr_word(clr_word), .status(status), .raw_irq(raw_irq),
        .masked_irq(masked_irq), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_raw();
        logic [4:0] r = m_sticky;
        r[0] = (tx_level <= tx_thresh);
        r[4] = (rx_level > rx_thresh);
        return r;
    endfunction

    function automatic logic [4:0] exp_status();
        return {rx_full, rx_empty, tx_empty, tx_full, engine_busy};
    endfunction

    function automatic logic [4:0] next_sticky();
        logic [4:0] n = m_sticky;
        logic ca = clr_stb & clr_word[0];
        if (ca || (clr_stb & clr_word[3])) n[1] = 1'b0;
        if (ca || (clr_stb & clr_word[1])) n[2] = 1'b0;
        if (ca || (clr_stb & clr_word[2])) n[3] = 1'b0;
        if (tx_push & tx_full)  n[1] = 1'b1;
        if (rx_pop & rx_empty)  n[2] = 1'b1;
        if (rx_push & rx_full)  n[3] = 1'b1;
        return n;
    endfunction

    // check outputs for current inputs, then advance one clock; returns at negedge
    task automatic step();
        logic [4:0] r, nx;
        #1;
        r = exp_raw();
        chk("R1 status", status, exp_status());
        chk("R2 tx level flag", raw_irq[0], r[0]);
        chk("R4 tx overflow", raw_irq[1], r[1]);
        chk("R6 rx underflow", raw_irq[2], r[2]);
        chk("R5 rx overflow", raw_irq[3], r[3]);
        chk("R3 rx level flag", raw_irq[4], r[4]);
        chk("R10 masked", masked_irq, r & irq_mask);
        chk("R10 irq", irq, |(r & irq_mask));
        chk("R11 dma tx", dma_tx_req, dma_en[1] & r[0]);
        chk("R11 dma rx", dma_rx_req, dma_en[0] & r[4]);
        nx = next_sticky();
        @(posedge clk);
        m_sticky = rst_n ? nx : 5'b0;
        @(negedge clk);
    endtask

    task automatic set_levels(input int tl, input int rl);
        tx_level = LW'(tl); rx_level = LW'(rl);
        tx_full = (tl == DEPTH); tx_empty = (tl == 0);
        rx_full = (rl == DEPTH); rx_empty = (rl == 0);
    endtask

    task automatic idle();
        tx_push = 0; rx_push = 0; rx_pop = 0; clr_stb = 0; clr_word = '0;
    endtask

    function automatic int pick_level();
        int k = $urandom_range(0, 3);
        if (k == 0) return 0;
        if (k == 1) return DEPTH;
        return $urandom_range(0, DEPTH);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R12: events during reset leave sticky bits clear
        set_levels(DEPTH, DEPTH); tx_push = 1; rx_push = 1;
        repeat (3) step();
        chk("R12 sticky after reset", raw_irq[3:1], 3'b000);
        rst_n = 1; idle(); set_levels(0, 0);
        step();

        // R9: overflow and its own clear in the same cycle
        set_levels(DEPTH, 0); tx_push = 1; clr_stb = 1; clr_word = 4'b1000;
        step(); idle(); #1;
        chk("R9 event beats clear", raw_irq[1], 1'b1);
        step();
        // R7: single clear of transmit overflow only
        set_levels(0, 0); rx_pop = 1;
        step(); idle();
        clr_stb = 1; clr_word = 4'b1000;
        step(); idle(); #1;
        chk("R7 single clear", raw_irq[2:1], 2'b10);
        step();
        // R8: clear-all wipes all three
        set_levels(DEPTH, DEPTH); tx_push = 1; rx_push = 1;
        step(); idle(); set_levels(5, 5);
        clr_stb = 1; clr_word = 4'b0001;
        step(); idle(); #1;
        chk("R8 clear all", raw_irq[3:1], 3'b000);
        step();
        // R2 R3 boundary: level equal to threshold
        set_levels(7, 7); tx_thresh = 7; rx_thresh = 7; dma_en = 2'b11; irq_mask = 5'h1f;
        step();
        set_levels(8, 8);
        step();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            set_levels(pick_level(), pick_level());
            if ($urandom_range(0, 7) == 0) begin
                tx_thresh = LW'($urandom_range(0, DEPTH));
                rx_thresh = LW'($urandom_range(0, DEPTH));
            end
            tx_push = ($urandom_range(0, 3) == 0);
            rx_push = ($urandom_range(0, 3) == 0);
            rx_pop  = ($urandom_range(0, 3) == 0);
            engine_busy = 1'($urandom);
            irq_mask = 5'($urandom);
            dma_en = 2'($urandom);
            clr_stb = ($urandom_range(0, 5) == 0);
            clr_word = 4'($urandom);
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            step();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule